// File: doc/BRIEF.md
# Completion Buffer with Register Rename Map

This block holds the results of instructions that have been dispatched but have not yet retired. Each instruction is given a slot in one of two pools of result entries, chosen by its class. The address-generation class (memory operations, branches, jumps, conditional moves) has one pool and the arithmetic class has the other. The slot number becomes the instruction's result tag. Execution units write results by tag and read operands by tag. Nothing reaches the architectural register file until the instruction is the oldest one still in flight.

At dispatch the block picks the lowest free slot in the requested pool. It points the destination register's map slot at the new tag. For each source register it reports either "take the architectural value" or the tag of the pending producer. Retirement drains a program-order queue one entry per cycle.

A result write carries a completion kind. When a mispredicted branch reaches the head, it commits and every younger entry is thrown away. When an excepting instruction reaches the head, nothing commits and every entry is thrown away. In both cases the map returns to all-architectural.

Top module: `cbuf_rename`

## Requirements
- R1: Tags 0 to AGEN_ENTRIES-1 (0..13 by default) belong to the address-generation pool, selected by alloc_cls=0. Tags from AGEN_ENTRIES up to AGEN_ENTRIES+ALU_ENTRIES-1 (14..31) belong to the arithmetic pool, selected by alloc_cls=1. alloc_id shows the lowest-numbered free tag of the selected pool.
- R2: alloc_ready is low exactly when the selected pool has no free tag, or a flush is happening this cycle. A full pool does not block the other pool.
- R3: For each source register, src_pend=1 and src_id=tag when the map slot names a pending producer, otherwise src_pend=0. The lookup reflects the map before this cycle's allocation, so an instruction whose destination equals its source sees the older producer.
- R4: A write with wr_valid sets the entry's result and done flag. A read port with a live, done entry returns rd_ready=1 and its data. A write to a tag that is not allocated is ignored.
- R5: Retirement is in allocation order, at most one per cycle. commit_valid rises in the cycle after the oldest entry's result is written and shows its destination, data and PC. Done younger entries wait behind an unfinished older one.
- R6: On retirement a map slot returns to "architectural" only if it still names the retiring tag. Otherwise it keeps its newer producer.
- R7: wr_kind=1 marks a mispredicted branch. At the head it commits (commit_valid=1) with flush_mispredict=1. All other entries are discarded, the map becomes all-architectural and both pools are fully free.
- R8: wr_kind=2 or 3 marks an exception. At the head flush_exception=1 and commit_valid=0. All entries are discarded and the map becomes all-architectural.
- R9: After reset all tags are free, every map slot is architectural, no read port is ready and nothing commits.
- R10: A tag freed by retirement or flush is handed out again by later allocations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Dispatch request |
| alloc_cls | input | 1 | 0 address-generation class, 1 arithmetic class |
| alloc_has_dst | input | 1 | Instruction writes a register |
| alloc_dst | input | 5 | Destination register |
| alloc_pc | input | 32 | PC recorded with the entry |
| alloc_src | input | 2x5 | Source register numbers to look up |
| alloc_ready | output | 1 | A tag is available in the selected pool |
| alloc_id | output | 5 | Tag given to the dispatched instruction |
| src_pend | output | 2 | Source has a pending producer |
| src_id | output | 2x5 | Producer tag per source |
| wr_valid | input | 1 | Result write |
| wr_id | input | 5 | Tag being written |
| wr_data | input | 32 | Result value |
| wr_kind | input | 2 | 0 normal, 1 mispredict, 2/3 exception |
| rd_id | input | NUM_RD x5 | Operand read tags |
| rd_ready | output | NUM_RD | Entry holds a finished result |
| rd_data | output | NUM_RD x32 | Entry result |
| commit_valid | output | 1 | Oldest entry retires to architectural state |
| commit_wen | output | 1 | Retiring entry writes a register |
| commit_reg | output | 5 | Register written |
| commit_data | output | 32 | Value written |
| commit_pc | output | 32 | PC of the retiring instruction |
| flush_mispredict | output | 1 | Mispredict flush this cycle |
| flush_exception | output | 1 | Exception flush this cycle |

## Verification
Several rules are checked on every cycle. Each pool hands out tags only from its own range and only tags that are not in use. Occupancy never exceeds the total entry count. A pending map slot always names a live entry. An exception never coincides with a commit, and a mispredict leaves the buffer empty on the next cycle. The bench scenarios are needed for the rest: the exact value of each producer tag, program-order retirement behind an unfinished older entry, the rule that keeps a newer map producer, writes to discarded tags being ignored, and tag reuse after flushes.

// File: rtl/cbuf_pkg.sv
`timescale 1ns/1ps
package cbuf_pkg;
    localparam int CB_AGEN_N = 14;
    localparam int CB_ALU_N  = 18;
    localparam int CB_REG_W  = 5;
    localparam int CB_DATA_W = 32;
    localparam int CB_PC_W   = 32;
    localparam int CB_NSRC   = 2;

    typedef enum logic [1:0] {
        WB_NORMAL  = 2'd0,
        WB_MISPRED = 2'd1,
        WB_EXCEPT  = 2'd2
    } wb_kind_e;

    typedef struct packed {
        logic                 valid;
        logic                 done;
        logic [1:0]           kind;
        logic                 has_dst;
        logic [CB_REG_W-1:0]  dst;
        logic [CB_PC_W-1:0]   pc;
        logic [CB_DATA_W-1:0] data;
    } cb_entry_t;

    function automatic logic kind_is_fault(input logic [1:0] k);
        return k[1];
    endfunction
endpackage

// File: rtl/cbuf_pool_pick.sv
`timescale 1ns/1ps
module cbuf_pool_pick #(
    parameter int N    = 14,
    parameter int BASE = 0,
    parameter int IDW  = 5
) (
    input  logic [N-1:0]   busy,
    output logic           any_free,
    output logic [IDW-1:0] pick_id
);
    always_comb begin
        any_free = 1'b0;
        pick_id  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                any_free = 1'b1;
                pick_id  = IDW'(BASE + i);
            end
        end
    end
endmodule

// File: rtl/cbuf_order_q.sv
`timescale 1ns/1ps
module cbuf_order_q #(
    parameter int DEPTH = 32,
    parameter int IDW   = 5,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clear,
    input  logic           push,
    input  logic [IDW-1:0] push_id,
    input  logic           pop,
    output logic           head_valid,
    output logic [IDW-1:0] head_id,
    output logic [CW-1:0]  count
);
    logic [IDW-1:0] slots [DEPTH];
    logic [PW-1:0]  rptr, wptr;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            rptr  <= '0;
            wptr  <= '0;
            count <= '0;
        end else begin
            if (push) begin
                slots[wptr] <= push_id;
                wptr        <= bump(wptr);
            end
            if (pop) rptr <= bump(rptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head_valid = (count != '0);
    assign head_id    = slots[rptr];
endmodule

// File: rtl/cbuf_rename_map.sv
`timescale 1ns/1ps
module cbuf_rename_map #(
    parameter int RW    = 5,
    parameter int IDW   = 5,
    parameter int NLOOK = 2,
    localparam int NREG = 1 << RW
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      clear,
    input  logic                      set_en,
    input  logic [RW-1:0]             set_reg,
    input  logic [IDW-1:0]            set_id,
    input  logic                      clr_en,
    input  logic [RW-1:0]             clr_reg,
    input  logic [IDW-1:0]            clr_id,
    input  logic [NLOOK-1:0][RW-1:0]  look_reg,
    output logic [NLOOK-1:0]          look_pend,
    output logic [NLOOK-1:0][IDW-1:0] look_id
);
    logic [NREG-1:0] pend;
    logic [IDW-1:0]  prod [NREG];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pend <= '0;
        end else begin
            for (int r = 0; r < NREG; r++) begin
                if (set_en && set_reg == RW'(r)) begin
                    pend[r] <= 1'b1;
                    prod[r] <= set_id;
                end else if (clr_en && clr_reg == RW'(r) && pend[r] && prod[r] == clr_id) begin
                    pend[r] <= 1'b0;
                end
            end
        end
    end

    for (genvar k = 0; k < NLOOK; k++) begin : g_look
        assign look_pend[k] = pend[look_reg[k]];
        assign look_id[k]   = prod[look_reg[k]];
    end
endmodule

// File: rtl/cbuf_rename.sv
`timescale 1ns/1ps
module cbuf_rename
    import cbuf_pkg::*;
#(
    parameter int AGEN_ENTRIES = CB_AGEN_N,
    parameter int ALU_ENTRIES  = CB_ALU_N,
    parameter int NUM_RD       = 2,
    localparam int TOTAL = AGEN_ENTRIES + ALU_ENTRIES,
    localparam int IDW   = $clog2(TOTAL),
    localparam int CW    = $clog2(TOTAL + 1),
    localparam int RW    = CB_REG_W,
    localparam int DW    = CB_DATA_W,
    localparam int PCW   = CB_PC_W,
    localparam int NSRC  = CB_NSRC
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       alloc_valid,
    input  logic                       alloc_cls,
    input  logic                       alloc_has_dst,
    input  logic [RW-1:0]              alloc_dst,
    input  logic [PCW-1:0]             alloc_pc,
    input  logic [NSRC-1:0][RW-1:0]    alloc_src,
    output logic                       alloc_ready,
    output logic [IDW-1:0]             alloc_id,
    output logic [NSRC-1:0]            src_pend,
    output logic [NSRC-1:0][IDW-1:0]   src_id,
    input  logic                       wr_valid,
    input  logic [IDW-1:0]             wr_id,
    input  logic [DW-1:0]              wr_data,
    input  logic [1:0]                 wr_kind,
    input  logic [NUM_RD-1:0][IDW-1:0] rd_id,
    output logic [NUM_RD-1:0]          rd_ready,
    output logic [NUM_RD-1:0][DW-1:0]  rd_data,
    output logic                       commit_valid,
    output logic                       commit_wen,
    output logic [RW-1:0]              commit_reg,
    output logic [DW-1:0]              commit_data,
    output logic [PCW-1:0]             commit_pc,
    output logic                       flush_mispredict,
    output logic                       flush_exception
);
    cb_entry_t        ent [TOTAL];
    logic [TOTAL-1:0] busy;
    logic             agen_free, alu_free;
    logic [IDW-1:0]   agen_pick, alu_pick;
    logic             head_valid;
    logic [IDW-1:0]   head_id;
    logic [CW-1:0]    q_count;
    cb_entry_t        head;
    logic             head_ready, flush, alloc_fire;

    for (genvar i = 0; i < TOTAL; i++) begin : g_busy
        assign busy[i] = ent[i].valid;
    end

    cbuf_pool_pick #(.N(AGEN_ENTRIES), .BASE(0), .IDW(IDW)) u_agen_pick (
        .busy(busy[AGEN_ENTRIES-1:0]), .any_free(agen_free), .pick_id(agen_pick));

    cbuf_pool_pick #(.N(ALU_ENTRIES), .BASE(AGEN_ENTRIES), .IDW(IDW)) u_alu_pick (
        .busy(busy[TOTAL-1:AGEN_ENTRIES]), .any_free(alu_free), .pick_id(alu_pick));

    assign head       = ent[head_id];
    assign head_ready = head_valid && head.valid && head.done;
    assign flush      = head_ready && (head.kind != WB_NORMAL);

    assign alloc_id    = alloc_cls ? alu_pick : agen_pick;
    assign alloc_ready = (alloc_cls ? alu_free : agen_free) && !flush;
    assign alloc_fire  = alloc_valid && alloc_ready;

    assign commit_valid     = head_ready && !kind_is_fault(head.kind);
    assign commit_wen       = commit_valid && head.has_dst;
    assign commit_reg       = head.dst;
    assign commit_data      = head.data;
    assign commit_pc        = head.pc;
    assign flush_mispredict = head_ready && head.kind == WB_MISPRED;
    assign flush_exception  = head_ready && kind_is_fault(head.kind);

    cbuf_order_q #(.DEPTH(TOTAL), .IDW(IDW)) u_order (
        .clk(clk), .rst(rst), .clear(flush),
        .push(alloc_fire), .push_id(alloc_id), .pop(head_ready),
        .head_valid(head_valid), .head_id(head_id), .count(q_count));

    cbuf_rename_map #(.RW(RW), .IDW(IDW), .NLOOK(NSRC)) u_map (
        .clk(clk), .rst(rst), .clear(flush),
        .set_en(alloc_fire && alloc_has_dst), .set_reg(alloc_dst), .set_id(alloc_id),
        .clr_en(commit_wen), .clr_reg(head.dst), .clr_id(head_id),
        .look_reg(alloc_src), .look_pend(src_pend), .look_id(src_id));

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int i = 0; i < TOTAL; i++) begin
                ent[i].valid <= 1'b0;
                ent[i].done  <= 1'b0;
            end
        end else begin
            for (int i = 0; i < TOTAL; i++) begin
                if (head_ready && head_id == IDW'(i)) begin
                    ent[i].valid <= 1'b0;
                end else if (alloc_fire && alloc_id == IDW'(i)) begin
                    ent[i].valid   <= 1'b1;
                    ent[i].done    <= 1'b0;
                    ent[i].kind    <= WB_NORMAL;
                    ent[i].has_dst <= alloc_has_dst;
                    ent[i].dst     <= alloc_dst;
                    ent[i].pc      <= alloc_pc;
                end else if (wr_valid && wr_id == IDW'(i) && ent[i].valid) begin
                    ent[i].done <= 1'b1;
                    ent[i].kind <= wr_kind;
                    ent[i].data <= wr_data;
                end
            end
        end
    end

    for (genvar k = 0; k < NUM_RD; k++) begin : g_rd
        assign rd_ready[k] = ent[rd_id[k]].valid && ent[rd_id[k]].done;
        assign rd_data[k]  = ent[rd_id[k]].data;
    end
endmodule

// File: rtl/cbuf_rename_chk.sv
`timescale 1ns/1ps
module cbuf_rename_chk #(
    parameter int TOTAL = 32,
    parameter int AGEN  = 14,
    parameter int IDW   = 5,
    parameter int CW    = 6,
    parameter int NSRC  = 2
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     alloc_valid,
    input logic                     alloc_ready,
    input logic                     alloc_cls,
    input logic [IDW-1:0]           alloc_id,
    input logic [NSRC-1:0]          src_pend,
    input logic [NSRC-1:0][IDW-1:0] src_id,
    input logic [TOTAL-1:0]         ent_valid,
    input logic                     commit_valid,
    input logic                     flush_mispredict,
    input logic                     flush_exception,
    input logic [CW-1:0]            occ
);
    assert_agen_range_R1: assert property (@(posedge clk) disable iff (rst)
        (alloc_valid && alloc_ready && alloc_cls == 1'b0) |-> alloc_id < IDW'(AGEN));

    assert_alu_range_R1: assert property (@(posedge clk) disable iff (rst)
        (alloc_valid && alloc_ready && alloc_cls == 1'b1) |-> alloc_id >= IDW'(AGEN));

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        occ <= CW'(TOTAL));

    assert_pick_free_R2: assert property (@(posedge clk) disable iff (rst)
        (alloc_valid && alloc_ready) |-> !ent_valid[alloc_id]);

    for (genvar k = 0; k < NSRC; k++) begin : g_src
        assert_src_live_R3: assert property (@(posedge clk) disable iff (rst)
            src_pend[k] |-> ent_valid[src_id[k]]);
    end

    assert_mispredict_drain_R7: assert property (@(posedge clk) disable iff (rst)
        flush_mispredict |=> (occ == '0 && ent_valid == '0));

    assert_exception_no_commit_R8: assert property (@(posedge clk) disable iff (rst)
        flush_exception |-> !commit_valid);

    assert_reset_empty_R9: assert property (@(posedge clk)
        rst |=> (occ == '0 && ent_valid == '0));
endmodule

bind cbuf_rename cbuf_rename_chk #(
    .TOTAL(TOTAL), .AGEN(AGEN_ENTRIES), .IDW(IDW), .CW(CW), .NSRC(NSRC)
) u_chk (
    .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_cls(alloc_cls), .alloc_id(alloc_id), .src_pend(src_pend), .src_id(src_id),
    .ent_valid(busy), .commit_valid(commit_valid), .flush_mispredict(flush_mispredict),
    .flush_exception(flush_exception), .occ(q_count)
);

// File: tb/cbuf_rename_bench.sv
`timescale 1ns/1ps
module cbuf_rename_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic            alloc_valid, alloc_cls, alloc_has_dst;
    logic [4:0]      alloc_dst;
    logic [31:0]     alloc_pc;
    logic [1:0][4:0] alloc_src;
    logic            alloc_ready;
    logic [4:0]      alloc_id;
    logic [1:0]      src_pend;
    logic [1:0][4:0] src_id;
    logic            wr_valid;
    logic [4:0]      wr_id;
    logic [31:0]     wr_data;
    logic [1:0]      wr_kind;
    logic [1:0][4:0] rd_id;
    logic [1:0]      rd_ready;
    logic [1:0][31:0] rd_data;
    logic            commit_valid, commit_wen;
    logic [4:0]      commit_reg;
    logic [31:0]     commit_data, commit_pc;
    logic            flush_mispredict, flush_exception;

    cbuf_rename u_cbuf_rename (.*);

    int checks = 0;
    int failures = 0;

    typedef struct packed {
        logic       cls;
        logic [4:0] dst;
        logic [4:0] src;
        logic [4:0] eid;
        logic       epend;
        logic [4:0] esid;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{1'b0, 5'd5, 5'd5, 5'd0,  1'b0, 5'd0},
        '{1'b1, 5'd6, 5'd5, 5'd14, 1'b1, 5'd0},
        '{1'b1, 5'd5, 5'd5, 5'd15, 1'b1, 5'd0},
        '{1'b0, 5'd7, 5'd5, 5'd1,  1'b1, 5'd15},
        '{1'b1, 5'd8, 5'd7, 5'd16, 1'b1, 5'd1},
        '{1'b0, 5'd9, 5'd3, 5'd2,  1'b0, 5'd0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clr_in();
        alloc_valid = 0; alloc_cls = 0; alloc_has_dst = 0; alloc_dst = 0;
        alloc_pc = 0; alloc_src = '0; wr_valid = 0; wr_id = 0; wr_data = 0; wr_kind = 0;
    endtask

    task automatic drive_alloc(input logic cls, input logic has, input logic [4:0] dst,
                               input logic [31:0] pc, input logic [4:0] s0, input logic [4:0] s1);
        @(negedge clk); clr_in();
        alloc_valid = 1; alloc_cls = cls; alloc_has_dst = has; alloc_dst = dst;
        alloc_pc = pc; alloc_src[0] = s0; alloc_src[1] = s1;
        #1;
    endtask

    task automatic drive_wr(input logic [4:0] id, input logic [31:0] d, input logic [1:0] k);
        @(negedge clk); clr_in();
        wr_valid = 1; wr_id = id; wr_data = d; wr_kind = k;
        #1;
    endtask

    task automatic drive_idle(input logic [4:0] s0, input logic [4:0] s1);
        @(negedge clk); clr_in();
        alloc_src[0] = s0; alloc_src[1] = s1;
        #1;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        clr_in();
        rd_id = '0;
        repeat (3) @(negedge clk);
        rst = 0;

        // R9: reset state
        drive_idle(5'd5, 5'd6);
        check("R9 commit_valid", commit_valid, 0);
        check("R9 alloc_ready", alloc_ready, 1);
        check("R9 src_pend", src_pend, 0);
        check("R9 rd_ready", rd_ready, 0);
        check("R9 flushes", {flush_mispredict, flush_exception}, 0);

        // R1 / R3: allocation table
        for (int i = 0; i < 6; i++) begin
            drive_alloc(VEC[i].cls, 1'b1, VEC[i].dst, 32'h100 + 32'(4 * i), VEC[i].src, 5'd0);
            check("R1 alloc_ready", alloc_ready, 1);
            check("R1 alloc_id", alloc_id, VEC[i].eid);
            check("R3 src0_pend", src_pend[0], VEC[i].epend);
            if (VEC[i].epend) check("R3 src0_id", src_id[0], VEC[i].esid);
            check("R3 src1_pend", src_pend[1], 0);
        end

        // R5: younger done entry waits; R4 read ports
        drive_wr(5'd14, 32'h66, 2'd0);
        rd_id[0] = 5'd14; rd_id[1] = 5'd0;
        drive_idle(5'd0, 5'd0);
        check("R5 younger waits", commit_valid, 0);
        check("R4 rd_ready0", rd_ready[0], 1);
        check("R4 rd_data0", rd_data[0], 32'h66);
        check("R4 rd_ready1", rd_ready[1], 0);

        drive_wr(5'd0, 32'hA0, 2'd0);
        drive_idle(5'd5, 5'd6);
        check("R5 commit_valid", commit_valid, 1);
        check("R5 commit_wen", commit_wen, 1);
        check("R5 commit_reg", commit_reg, 5);
        check("R5 commit_data", commit_data, 32'hA0);
        check("R5 commit_pc", commit_pc, 32'h100);
        check("R6 r5 kept pend", src_pend[0], 1);
        check("R6 r5 kept id", src_id[0], 15);

        drive_idle(5'd6, 5'd5);
        check("R5 second commit", commit_valid, 1);
        check("R5 second reg", commit_reg, 6);
        check("R5 second data", commit_data, 32'h66);
        check("R5 second pc", commit_pc, 32'h104);

        drive_idle(5'd6, 5'd5);
        check("R5 stalls on head", commit_valid, 0);
        check("R6 r6 cleared", src_pend[0], 0);
        check("R6 r5 still newer", src_pend[1], 1);
        check("R6 r5 id", src_id[1], 15);

        // R10 / R1: fill the address-generation pool, id 0 reused
        for (int k = 0; k < 12; k++) begin
            drive_alloc(1'b0, 1'b0, 5'd0, 32'h180, 5'd0, 5'd0);
            check("R10 reuse id", alloc_id, (k == 0) ? 32'd0 : 32'(k + 2));
            check("R10 ready", alloc_ready, 1);
        end

        // R2: full pool stalls, other pool unaffected
        drive_alloc(1'b0, 1'b0, 5'd0, 32'h1C0, 5'd0, 5'd0);
        check("R2 agen full", alloc_ready, 0);
        drive_alloc(1'b1, 1'b0, 5'd0, 32'h1C4, 5'd0, 5'd0);
        check("R2 alu ready", alloc_ready, 1);
        check("R10 alu reuse 14", alloc_id, 14);

        // R8: exception at head
        drive_wr(5'd15, 32'h55, 2'd2);
        drive_idle(5'd5, 5'd7);
        check("R8 flush_exception", flush_exception, 1);
        check("R8 no commit", commit_valid, 0);
        check("R8 no mispredict", flush_mispredict, 0);

        drive_wr(5'd1, 32'h11, 2'd0);
        rd_id[0] = 5'd1;
        drive_idle(5'd5, 5'd7);
        check("R8 map cleared", src_pend, 0);
        check("R4 write to freed tag ignored", rd_ready[0], 0);
        check("R8 quiet after", commit_valid, 0);

        // R7: mispredicted branch
        drive_alloc(1'b1, 1'b1, 5'd10, 32'h200, 5'd0, 5'd0);
        check("R10 alu after flush", alloc_id, 14);
        drive_alloc(1'b0, 1'b1, 5'd11, 32'h204, 5'd0, 5'd0);
        check("R10 agen after flush", alloc_id, 0);
        drive_alloc(1'b0, 1'b1, 5'd12, 32'h208, 5'd0, 5'd0);
        check("R1 next agen", alloc_id, 1);
        drive_wr(5'd1, 32'h12, 2'd0);
        drive_wr(5'd14, 32'h77, 2'd1);
        drive_idle(5'd11, 5'd12);
        check("R7 commit_valid", commit_valid, 1);
        check("R7 commit_reg", commit_reg, 10);
        check("R7 commit_data", commit_data, 32'h77);
        check("R7 commit_pc", commit_pc, 32'h200);
        check("R7 flush_mispredict", flush_mispredict, 1);

        drive_idle(5'd11, 5'd12);
        check("R7 nothing left", commit_valid, 0);
        check("R7 map cleared", src_pend, 0);
        check("R7 younger done discarded", rd_ready[0], 0);

        drive_alloc(1'b0, 1'b1, 5'd3, 32'h300, 5'd0, 5'd0);
        check("R7 pool free again", alloc_id, 0);
        check("R7 ready", alloc_ready, 1);

        drive_idle(5'd0, 5'd0);
        summary();
        $finish;
    end
endmodule